// File: doc/BRIEF.md
# Grouped GPIO Bank with Direction and Mode Control

This block provides a bank of general-purpose I/O lines arranged in groups of eight. Line n sits in group n/8, at bit n%8 of that group's bytes. A processor reaches each group's data byte on an I/O bus. The byte's address is a fixed base address plus the group index. A write sets the group's output latches. A read returns the pin levels of the group's lines, after a two-flop synchroniser.

A separate configuration port loads two per-group bytes. The direction byte marks each line as output (1) or input (0). The mode byte selects the plain I/O function for each line. The mode switch exists only on the lowest groups. The remaining groups are always in plain I/O mode and ignore mode writes. A line drives its pad only when its direction bit is set and its mode allows it. The pad is modelled as separate out, output-enable and in vectors.

Top module: `gpio_bank`

## Requirements
- R1: Line n maps to group n/8, bit n%8. The same mapping applies to `pad_out`, `pad_oe` and `pad_in`.
- R2: An I/O write with `io_addr` equal to BASE_ADDR+g, where g < NUM_GROUPS, replaces all 8 output latches of group g at the next rising edge. Every other group keeps its latches. `pad_out` always shows the latches.
- R3: An I/O read with `io_addr` equal to BASE_ADDR+g returns the synchronised `pad_in` byte of group g on `io_rdata` in the same cycle, with `io_rd_hit` at 1.
- R4: A change on `pad_in` is not visible on a data read after one rising edge. It is visible after the second rising edge.
- R5: A configuration write with `cfg_sel`=0 loads the direction byte of group `cfg_grp` at the next rising edge. A direction bit of 1 makes the line an output. `pad_oe` is 1 only where the direction bit is 1 and the line is in plain I/O mode.
- R6: Groups below MODE_GROUPS (default 5) are in plain I/O mode only where their mode byte has a 1. The mode byte is loaded with `cfg_sel`=1. Groups at or above MODE_GROUPS are always in plain I/O mode, and a mode write to them changes nothing on `pad_oe`.
- R7: Reset clears all direction bits, mode bits and output latches. After reset, `pad_out` and `pad_oe` are all zero.
- R8: An I/O access outside BASE_ADDR to BASE_ADDR+NUM_GROUPS-1 changes no latch. A read there keeps `io_rd_hit` at 0 and `io_rdata` at 0.
- R9: A latch written while its line is an input keeps its value. It appears on the pad once the line is switched to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W | I/O bus address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data; zero when not decoded |
| io_rd_hit | output | 1 | High when a read is decoded by this bank |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = direction byte, 1 = mode byte |
| cfg_grp | input | 3 | Group addressed by the configuration write |
| cfg_wdata | input | 8 | Configuration byte |
| pad_in | input | 8*NUM_GROUPS | Pin levels from the pads |
| pad_out | output | 8*NUM_GROUPS | Output latch value per line |
| pad_oe | output | 8*NUM_GROUPS | Pad drive enable per line |

## Verification
The data path is tried with a vector table. Each entry writes a one-hot, alternating or all-ones byte to a chosen group and presents a different pin pattern on the same group. This separates a correct group and bit mapping from swapped groups, shifted bits and latch-to-read leakage. The configuration patterns give the direction and mode bytes partly overlapping values. The expected drive enable is then their intersection on a mode group, and the direction byte alone on a fixed group, which exposes a missing gate or a wrongly placed mode boundary. Directed cases probe the synchroniser depth, addresses just below and just above the window, latches held across a direction change, and a reset in mid-run.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned LINES_PER_GROUP = 8;
   localparam int unsigned WINDOW_BYTES    = 8;

   typedef enum logic {
      CFG_DIR  = 1'b0,
      CFG_MODE = 1'b1
   } cfg_sel_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stage1_q;
   logic [WIDTH-1:0] stage2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else begin
         stage1_q <= din;
         stage2_q <= stage1_q;
      end
   end

   assign dout = stage2_q;

   // edges seen since reset, saturating at 2
   logic [1:0] warm_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             warm_cnt <= 2'd0;
      else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
   end

   assert_two_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_cnt == 2'd2) |-> (dout == $past(din, 2)))
      else $error("synchroniser depth is not two stages");
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
   parameter int unsigned ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   parameter int unsigned NUM_GROUPS = 8,
   localparam int unsigned GRP_W     = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [GRP_W-1:0]  grp
);
   logic [ADDR_W-1:0] offset;

   always_comb begin
      offset = addr - BASE_ADDR;
      hit    = (addr >= BASE_ADDR) && (offset < ADDR_W'(NUM_GROUPS));
      grp    = offset[GRP_W-1:0];
   end
endmodule

// File: rtl/gpio_group.sv
module gpio_group
   import gpio_bank_pkg::*;
#(
   parameter bit HAS_MODE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_we,
   input  logic [7:0] data_wdata,
   input  logic       dir_we,
   input  logic       mode_we,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] latch_q,
   output logic [7:0] drive_en
);
   logic [7:0] dir_q;
   logic [7:0] mode_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latch_q <= '0;
      else if (data_we) latch_q <= data_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_we) dir_q <= cfg_wdata;
   end

   if (HAS_MODE) begin : g_switched
      logic [7:0] mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mode_q <= '0;
         else if (mode_we) mode_q <= cfg_wdata;
      end
      assign mode_eff = mode_q;
   end else begin : g_fixed
      assign mode_eff = '1;

      assert_mode_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_we && !dir_we) |=> $stable(drive_en))
         else $error("mode write altered a fixed-mode group");
   end

   assign drive_en = dir_q & mode_eff;

   assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !data_we |=> $stable(latch_q))
      else $error("latch changed without a data write");

   assert_oe_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(dir_we || mode_we) |=> $stable(drive_en))
      else $error("drive enable changed without a configuration write");
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0A00,
   parameter int unsigned       NUM_GROUPS  = 8,
   parameter int unsigned       MODE_GROUPS = 5,
   localparam int unsigned      NUM_LINES   = NUM_GROUPS * LINES_PER_GROUP,
   localparam int unsigned      GRP_W       = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    io_addr,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [7:0]           io_wdata,
   output logic [7:0]           io_rdata,
   output logic                 io_rd_hit,
   input  logic                 cfg_wr,
   input  logic                 cfg_sel,
   input  logic [GRP_W-1:0]     cfg_grp,
   input  logic [7:0]           cfg_wdata,
   input  logic [NUM_LINES-1:0] pad_in,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe
);
   if (NUM_GROUPS < 1 || NUM_GROUPS > WINDOW_BYTES) begin : g_bad_groups
      $error("NUM_GROUPS must lie in 1..8");
   end
   if (MODE_GROUPS > NUM_GROUPS) begin : g_bad_mode
      $error("MODE_GROUPS must not exceed NUM_GROUPS");
   end
   if (ADDR_W < GRP_W) begin : g_bad_addr
      $error("ADDR_W too narrow");
   end

   logic                 addr_hit;
   logic [GRP_W-1:0]     addr_grp;
   logic [NUM_LINES-1:0] pins_sync;
   cfg_sel_e             sel;

   assign sel = cfg_sel_e'(cfg_sel);

   gpio_addr_dec #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .NUM_GROUPS(NUM_GROUPS)
   ) u_dec (
      .addr(io_addr),
      .hit (addr_hit),
      .grp (addr_grp)
   );

   gpio_sync2 #(.WIDTH(NUM_LINES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pad_in),
      .dout (pins_sync)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic data_we, dir_we, mode_we;
      assign data_we = io_wr && addr_hit && (addr_grp == GRP_W'(g));
      assign dir_we  = cfg_wr && (sel == CFG_DIR)  && (cfg_grp == GRP_W'(g));
      assign mode_we = cfg_wr && (sel == CFG_MODE) && (cfg_grp == GRP_W'(g));

      gpio_group #(.HAS_MODE(g < MODE_GROUPS)) u_group (
         .clk       (clk),
         .rst_n     (rst_n),
         .data_we   (data_we),
         .data_wdata(io_wdata),
         .dir_we    (dir_we),
         .mode_we   (mode_we),
         .cfg_wdata (cfg_wdata),
         .latch_q   (pad_out[g*LINES_PER_GROUP +: LINES_PER_GROUP]),
         .drive_en  (pad_oe[g*LINES_PER_GROUP +: LINES_PER_GROUP])
      );
   end

   always_comb begin
      io_rd_hit = io_rd && addr_hit;
      io_rdata  = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (io_rd_hit && (addr_grp == GRP_W'(g)))
            io_rdata = pins_sync[g*LINES_PER_GROUP +: LINES_PER_GROUP];
      end
   end

   assert_no_drive_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_addr < BASE_ADDR) || ({1'b0, io_addr} >= {1'b0, BASE_ADDR} + (ADDR_W+1)'(NUM_GROUPS)))
         |-> (!io_rd_hit && io_rdata == 8'h00))
      else $error("read bus driven outside the window");
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
   localparam int unsigned    NG   = 8;
   localparam int unsigned    NL   = NG * 8;
   localparam logic [15:0]    BASE = 16'h0A00;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   io_addr = '0;
   logic          io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]    io_wdata = '0;
   logic [7:0]    io_rdata;
   logic          io_rd_hit;
   logic          cfg_wr = 1'b0, cfg_sel = 1'b0;
   logic [2:0]    cfg_grp = '0;
   logic [7:0]    cfg_wdata = '0;
   logic [NL-1:0] pad_in = '0;
   logic [NL-1:0] pad_out, pad_oe;

   int total = 0;
   int bad   = 0;
   logic [NL-1:0] exp_out = '0;

   always #5 clk = ~clk;

   gpio_bank #(.BASE_ADDR(BASE), .NUM_GROUPS(NG), .MODE_GROUPS(5)) u_gpio_bank (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rd_hit(io_rd_hit),
      .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_grp(cfg_grp), .cfg_wdata(cfg_wdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic check(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk); io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic h);
      @(negedge clk); io_addr = a; io_rd = 1'b1;
      #1; d = io_rdata; h = io_rd_hit;
      io_rd = 1'b0;
   endtask

   task automatic cfg_write(input logic s, input logic [2:0] g, input logic [7:0] d);
      @(negedge clk); cfg_sel = s; cfg_grp = g; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   // {group, latch byte, pin byte}
   localparam logic [18:0] VEC [6] = '{
      {3'd0, 8'h01, 8'h80},
      {3'd1, 8'hA5, 8'h5A},
      {3'd3, 8'h01, 8'hFF},
      {3'd5, 8'h3C, 8'h00},
      {3'd7, 8'hFF, 8'h96},
      {3'd6, 8'h80, 8'h01}
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [7:0] rd;
      logic       hit;
      repeat (3) @(negedge clk);
      // R7: reset state
      check("R7 pad_out", pad_out, '0);
      check("R7 pad_oe", pad_oe, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3: table walk
      for (int i = 0; i < 6; i++) begin
         logic [2:0] g;
         logic [7:0] wd, pn;
         {g, wd, pn} = VEC[i];
         io_write(BASE + 16'(g), wd);
         exp_out[g*8 +: 8] = wd;
         check("R2 R1 latch map", pad_out, exp_out);
         pad_in[g*8 +: 8] = pn;
         repeat (2) @(negedge clk);
         io_read(BASE + 16'(g), rd, hit);
         check("R3 read data", NL'(rd), NL'(pn));
         check("R3 read hit", NL'(hit), NL'(1));
      end

      // R4: two-flop latency
      @(negedge clk); pad_in[15:8] = 8'hC3;
      io_addr = BASE + 16'd1; io_rd = 1'b1;
      #1; check("R4 same cycle", NL'(io_rdata), NL'(8'h5A));
      @(negedge clk); #1; check("R4 after one edge", NL'(io_rdata), NL'(8'h5A));
      @(negedge clk); #1; check("R4 after two edges", NL'(io_rdata), NL'(8'hC3));
      io_rd = 1'b0;

      // R5 R6: mode group 0
      cfg_write(1'b0, 3'd0, 8'hFF);
      check("R6 dir without mode", NL'(pad_oe[7:0]), NL'(0));
      cfg_write(1'b1, 3'd0, 8'h0F);
      check("R5 dir and mode", NL'(pad_oe[7:0]), NL'(8'h0F));
      cfg_write(1'b0, 3'd0, 8'h3C);
      check("R5 intersection", NL'(pad_oe[7:0]), NL'(8'h0C));
      // R6: boundary group 4 switched, group 5 fixed
      cfg_write(1'b0, 3'd4, 8'hF0);
      check("R6 group4 needs mode", NL'(pad_oe[39:32]), NL'(0));
      cfg_write(1'b0, 3'd5, 8'hA5);
      check("R6 group5 fixed", NL'(pad_oe[47:40]), NL'(8'hA5));
      cfg_write(1'b1, 3'd5, 8'h00);
      check("R6 mode write ignored", NL'(pad_oe[47:40]), NL'(8'hA5));
      check("R5 other groups off", NL'(pad_oe[NL-1:48]), NL'(0));

      // R8: outside window
      io_write(BASE + 16'd8, 8'h77);
      io_write(BASE - 16'd1, 8'h77);
      check("R8 no latch change", pad_out, exp_out);
      io_read(BASE + 16'd8, rd, hit);
      check("R8 read above", NL'({hit, rd}), NL'(0));
      io_read(BASE - 16'd1, rd, hit);
      check("R8 read below", NL'({hit, rd}), NL'(0));

      // R9: latch kept while input, driven after switch
      check("R9 latch held as input", NL'(pad_out[15:8]), NL'(8'hA5));
      cfg_write(1'b1, 3'd1, 8'hFF);
      cfg_write(1'b0, 3'd1, 8'h0F);
      check("R9 driven after switch", NL'(pad_out[15:8] & pad_oe[15:8]), NL'(8'h05));

      // R7: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      #1;
      check("R7 mid-run pad_out", pad_out, '0);
      check("R7 mid-run pad_oe", pad_oe, '0);
      @(negedge clk); rst_n = 1'b1;
      io_read(BASE + 16'd7, rd, hit);
      check("R7 sync cleared", NL'(rd), NL'(0));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule